// File: doc/BRIEF.md
# Interrupt-Capable Eight-Pin I/O Port

This block is one eight-pin general-purpose I/O port that sits behind a small synchronous register port. Every pin can be an input or an output. An output pin drives its bit of the data register. An input pin is brought into the clock domain, can be filtered against bounce, and can raise an interrupt.

The trigger condition for each pin is set by two separate bits. The first bit chooses between level detection and edge detection. The second bit chooses the sense: high or rising, or low or falling. Level interrupts follow the pin and are never held. Edge interrupts are held until software writes a one to that pin's bit in the acknowledge register. A per-pin enable gates every source. Software reads the resulting status byte, and the bits of that byte are ORed into a single interrupt line.

Writes happen at the clock edge when `reg_wen` is high. Read data is combinational from `reg_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset every register reads 0. All pins are inputs (`pad_oe` = 0), and `irq` and the status byte are 0.
- R2: The register map is: data at 0x00, direction at 0x10, detect-mode at 0x90, sense at 0x94, acknowledge at 0x98, enable at 0x9C, status at 0xA0, debounce at 0xA8. Bit i belongs to pin i. A direction bit of 1 sets `pad_oe[i]` and drives `pad_out[i]` from data bit i. Reading 0x00 returns the data bit for output pins and the conditioned input level for input pins. The acknowledge register and any unmapped offset read as 0.
- R3: When a pin's detect-mode bit is 0, its status bit follows the conditioned pin level. A sense bit of 1 asserts on a high level and a sense bit of 0 asserts on a low level. The bit clears by itself when the level goes away.
- R4: When a pin's detect-mode bit is 1, a rising edge (sense bit 1) or a falling edge (sense bit 0) of the conditioned level sets a held status bit. An edge of the other direction does nothing.
- R5: Writing the acknowledge register clears the held edge bit of every pin written as 1. Pins written as 0 keep their bit. Level-mode status is not affected by the write.
- R6: If an edge is detected in the same cycle as an acknowledge write for that pin, the edge wins and the status bit stays 1.
- R7: A pin reports status only while its enable bit is 1. Clearing the enable bit drops its status and discards any held edge.
- R8: A pin configured as an output never reports status.
- R9: Reading offset 0xA0 returns the status byte, and `irq` is 1 exactly when that byte is non-zero. Writes to 0xA0 are ignored.
- R10: With the debounce bit at 1, a new input level is accepted only after it has been seen on 4 consecutive synchronized samples, so a 2-cycle pulse is lost. With the debounce bit at 0, the same pulse is accepted.
- R11: Inputs pass through a two-flop synchronizer and a conditioning register. With debounce off, a pad change made before clock edge k is visible in the data read after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data, one bit per pin |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pad_in | input | 8 | Asynchronous pin input levels |
| pad_out | output | 8 | Output levels from the data register |
| pad_oe | output | 8 | Output enables, 1 = pin driven |
| irq | output | 1 | OR of the status byte |

## Verification
The bench aims an edge at the exact clock edge where an acknowledge write lands. A design that lets the acknowledge win would lose that interrupt, and the status byte would read 0 instead of 0xFF. Short pulses are sent with debounce on and off. A filter that is missing or too long either lets the pulse raise an edge or drops a slow, valid change. Other tests check that an acknowledge on some pins leaves the others held, that level status falls by itself, and that disabling a pin throws away a stored edge. A design that failed any of these would show stale or missing status bits. The exact cycle at which the data read sees a pad change is also checked, which catches a synchronizer with too many or too few stages.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_DATA = 8'h00;
    localparam logic [REG_AW-1:0] OFF_DIR  = 8'h10;
    localparam logic [REG_AW-1:0] OFF_MODE = 8'h90;
    localparam logic [REG_AW-1:0] OFF_SENS = 8'h94;
    localparam logic [REG_AW-1:0] OFF_ACK  = 8'h98;
    localparam logic [REG_AW-1:0] OFF_ENA  = 8'h9C;
    localparam logic [REG_AW-1:0] OFF_STAT = 8'hA0;
    localparam logic [REG_AW-1:0] OFF_DEB  = 8'hA8;

    // Per-pin configuration gathered from the register file.
    typedef struct packed {
        logic is_out;    // pin driven from data register
        logic edge_sel;  // 1: edge detection, 0: level detection
        logic sense_hi;  // 1: high / rising, 0: low / falling
        logic enable;    // interrupt source enabled
        logic debounce;  // input filter enabled
    } pin_cfg_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_MODE,
        SEL_SENS,
        SEL_ACK,
        SEL_ENA,
        SEL_STAT,
        SEL_DEB
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_DATA: s = SEL_DATA;
            OFF_DIR:  s = SEL_DIR;
            OFF_MODE: s = SEL_MODE;
            OFF_SENS: s = SEL_SENS;
            OFF_ACK:  s = SEL_ACK;
            OFF_ENA:  s = SEL_ENA;
            OFF_STAT: s = SEL_STAT;
            OFF_DEB:  s = SEL_DEB;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic level_match(input logic lvl, input logic sense_hi);
        return lvl == sense_hi;
    endfunction

    function automatic logic edge_match(input logic cur, input logic prev,
                                        input logic sense_hi);
        return sense_hi ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic                    reg_wen,
    input  logic [NPINS-1:0]        reg_wdata,
    output logic [NPINS-1:0]        reg_rdata,
    input  logic [NPINS-1:0]        lvl_vec,
    input  logic [NPINS-1:0]        status_vec,
    output pin_cfg_t [NPINS-1:0]    cfg_o,
    output logic [NPINS-1:0]        data_o,
    output logic [NPINS-1:0]        ack_o
);

    logic [NPINS-1:0] data_q, dir_q, mode_q, sens_q, ena_q, deb_q;
    reg_sel_e         sel;

    assign sel = decode_addr(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            mode_q <= '0;
            sens_q <= '0;
            ena_q  <= '0;
            deb_q  <= '0;
        end else if (reg_wen) begin
            case (sel)
                SEL_DATA: data_q <= reg_wdata;
                SEL_DIR:  dir_q  <= reg_wdata;
                SEL_MODE: mode_q <= reg_wdata;
                SEL_SENS: sens_q <= reg_wdata;
                SEL_ENA:  ena_q  <= reg_wdata;
                SEL_DEB:  deb_q  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Acknowledge is a one-cycle pulse per pin, never stored.
    assign ack_o = (reg_wen && sel == SEL_ACK) ? reg_wdata : '0;

    always_comb begin
        case (sel)
            SEL_DATA: reg_rdata = (data_q & dir_q) | (lvl_vec & ~dir_q);
            SEL_DIR:  reg_rdata = dir_q;
            SEL_MODE: reg_rdata = mode_q;
            SEL_SENS: reg_rdata = sens_q;
            SEL_ENA:  reg_rdata = ena_q;
            SEL_STAT: reg_rdata = status_vec;
            SEL_DEB:  reg_rdata = deb_q;
            default:  reg_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        assign cfg_o[i] = '{is_out:   dir_q[i],
                            edge_sel: mode_q[i],
                            sense_hi: sens_q[i],
                            enable:   ena_q[i],
                            debounce: deb_q[i]};
    end

    assign data_o = data_q;

endmodule

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_COUNT   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_i,
    input  logic deb_en_i,
    output logic lvl_o,
    output logic prev_o
);

    localparam int CNT_W = $clog2(DEB_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_COUNT - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    logic [CNT_W-1:0]       cnt_q;
    logic                   lvl_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
    end

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (!deb_en_i) begin
            lvl_q <= samp;
            cnt_q <= '0;
        end else if (samp == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            lvl_q <= samp;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_q;
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg_i,
    input  logic     lvl_i,
    input  logic     prev_i,
    input  logic     ack_i,
    output logic     hit_o,
    output logic     pend_o,
    output logic     status_o
);

    logic armed, edge_armed, pend_q;

    assign armed      = cfg_i.enable & ~cfg_i.is_out;
    assign edge_armed = armed & cfg_i.edge_sel;
    assign hit_o      = edge_armed & edge_match(lvl_i, prev_i, cfg_i.sense_hi);

    // A new edge takes priority over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)              pend_q <= 1'b0;
        else if (!edge_armed) pend_q <= 1'b0;
        else if (hit_o)       pend_q <= 1'b1;
        else if (ack_i)       pend_q <= 1'b0;
    end

    assign pend_o   = pend_q;
    assign status_o = armed & (cfg_i.edge_sel ? pend_q
                                              : level_match(lvl_i, cfg_i.sense_hi));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_COUNT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    pin_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0]     lvl_vec, prev_vec, ack_vec, hit_vec, pend_vec;
    logic [NPINS-1:0]     status_vec, en_vec, data_vec;

    gpio_reg_bank #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wen    (reg_wen),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lvl_vec    (lvl_vec),
        .status_vec (status_vec),
        .cfg_o      (cfg),
        .data_o     (data_vec),
        .ack_o      (ack_vec)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_in_cond #(
            .SYNC_STAGES (SYNC_STAGES),
            .DEB_COUNT   (DEB_COUNT)
        ) u_cond (
            .clk      (clk),
            .rst      (rst),
            .pad_i    (pad_in[i]),
            .deb_en_i (cfg[i].debounce),
            .lvl_o    (lvl_vec[i]),
            .prev_o   (prev_vec[i])
        );

        gpio_irq_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (cfg[i]),
            .lvl_i    (lvl_vec[i]),
            .prev_i   (prev_vec[i]),
            .ack_i    (ack_vec[i]),
            .hit_o    (hit_vec[i]),
            .pend_o   (pend_vec[i]),
            .status_o (status_vec[i])
        );

        assign pad_oe[i] = cfg[i].is_out;
        assign en_vec[i] = cfg[i].enable;
    end

    assign pad_out = data_vec;
    assign irq     = |status_vec;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wen,
    input logic [NPINS-1:0]  reg_wdata,
    input logic [NPINS-1:0]  reg_rdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic              irq,
    input logic [NPINS-1:0]  status_vec,
    input logic [NPINS-1:0]  en_vec,
    input logic [NPINS-1:0]  pend_vec,
    input logic [NPINS-1:0]  hit_vec,
    input logic [NPINS-1:0]  ack_vec
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && irq == 1'b0)); // R1

    AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == OFF_DIR) |=> pad_oe == $past(reg_wdata)); // R2

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (status_vec & ~en_vec) == '0); // R7

    AST_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (status_vec & pad_oe) == '0); // R8

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_STAT) |-> reg_rdata == status_vec); // R9

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
        AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
            hit_vec[i] |=> pend_vec[i]); // R6

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack_vec[i] && !hit_vec[i]) |=> !pend_vec[i]); // R5
    end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wen    (reg_wen),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pad_oe     (pad_oe),
    .irq        (irq),
    .status_vec (status_vec),
    .en_vec     (en_vec),
    .pend_vec   (pend_vec),
    .hit_vec    (hit_vec),
    .ack_vec    (ack_vec)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

    localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h10, A_MODE = 8'h90,
                           A_SENS = 8'h94, A_ACK = 8'h98, A_ENA = 8'h9C,
                           A_STAT = 8'hA0, A_DEB = 8'hA8;

    // Vector bits: [4] edge mode, [3] sense high, [2] pad before, [1] pad after, [0] expected status
    localparam int NVEC = 10;
    localparam logic [4:0] VECS [NVEC] = '{
        5'b01011, 5'b01100, 5'b00101, 5'b00010, 5'b11011,
        5'b11100, 5'b10101, 5'b10010, 5'b11000, 5'b01111
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wen = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe;
    logic       irq;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    gpio_irq_port uut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] v;
        idle(5);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        rd(A_DIR, v);  check("R1 dir", v, 8'h00);
        rd(A_MODE, v); check("R1 mode", v, 8'h00);
        rd(A_ENA, v);  check("R1 enable", v, 8'h00);
        rd(A_STAT, v); check("R1 status", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R3 / R4: table of trigger modes across all pins
        for (int k = 0; k < NVEC; k++) begin
            wr(A_ENA, 8'h00);
            wr(A_MODE, {8{VECS[k][4]}});
            wr(A_SENS, {8{VECS[k][3]}});
            pad_in = {8{VECS[k][2]}};
            idle(8);
            wr(A_ACK, 8'hFF);
            wr(A_ENA, 8'hFF);
            idle(8);
            pad_in = {8{VECS[k][1]}};
            idle(8);
            rd(A_STAT, v);
            check(VECS[k][4] ? "R4 edge vector" : "R3 level vector", v, {8{VECS[k][0]}});
            check("R9 irq vector", {7'd0, irq}, {7'd0, VECS[k][0]});
        end

        // R3: level status clears itself when the level leaves
        wr(A_ENA, 8'h00); wr(A_MODE, 8'h00); wr(A_SENS, 8'hFF);
        pad_in = 8'h00; idle(8); wr(A_ENA, 8'hFF);
        pad_in = 8'h3C; idle(8);
        rd(A_STAT, v); check("R3 level high follows", v, 8'h3C);
        wr(A_ACK, 8'hFF); idle(1);
        rd(A_STAT, v); check("R5 ack ignores level", v, 8'h3C);
        pad_in = 8'h00; idle(8);
        rd(A_STAT, v); check("R3 level self clear", v, 8'h00);

        // R5: partial acknowledge of held edges
        wr(A_ENA, 8'h00); wr(A_MODE, 8'hFF); wr(A_SENS, 8'hFF);
        idle(4); wr(A_ENA, 8'hFF);
        pad_in = 8'hFF; idle(8);
        pad_in = 8'h00; idle(8);
        rd(A_STAT, v); check("R4 edge held", v, 8'hFF);
        wr(A_ACK, 8'h0F); idle(1);
        rd(A_STAT, v); check("R5 partial ack", v, 8'hF0);
        wr(A_STAT, 8'hFF); idle(1);
        rd(A_STAT, v); check("R9 status write ignored", v, 8'hF0);
        rd(A_ACK, v);  check("R2 ack reads zero", v, 8'h00);

        // R6: new edge lands on the same edge as the acknowledge
        wr(A_ACK, 8'hFF);
        pad_in = 8'hFF; idle(8);
        pad_in = 8'h00; idle(8);
        pad_in = 8'hFF;
        idle(3);
        wr(A_ACK, 8'hFF);
        idle(2);
        rd(A_STAT, v); check("R6 edge beats ack", v, 8'hFF);
        wr(A_ACK, 8'hFF); idle(1);
        rd(A_STAT, v); check("R5 ack clears", v, 8'h00);

        // R7: disabling discards held edges
        pad_in = 8'h00; idle(8);
        pad_in = 8'hFF; idle(8);
        wr(A_ENA, 8'h55); idle(1);
        rd(A_STAT, v); check("R7 masked pins drop", v, 8'h55);
        wr(A_ENA, 8'hFF); idle(1);
        rd(A_STAT, v); check("R7 held edge discarded", v, 8'h55);

        // R10: debounce rejects short pulses
        wr(A_ACK, 8'hFF);
        pad_in = 8'h00; idle(8); wr(A_ACK, 8'hFF);
        pad_in = 8'hFF; idle(2); pad_in = 8'h00; idle(8);
        rd(A_STAT, v); check("R10 short pulse without filter", v, 8'hFF);
        wr(A_DEB, 8'hFF); wr(A_ACK, 8'hFF);
        pad_in = 8'hFF; idle(2); pad_in = 8'h00; idle(10);
        rd(A_STAT, v); check("R10 short pulse filtered", v, 8'h00);
        pad_in = 8'hFF; idle(10);
        rd(A_STAT, v); check("R10 stable level accepted", v, 8'hFF);
        wr(A_DEB, 8'h00); wr(A_ENA, 8'h00);

        // R11: synchronizer latency on the data read
        pad_in = 8'h00; idle(6);
        pad_in = 8'h01;
        idle(2);
        rd(A_DATA, v); check("R11 not yet visible", v, 8'h00);
        idle(1);
        rd(A_DATA, v); check("R11 visible after third edge", v, 8'h01);

        // R2: outputs and mixed data read
        pad_in = 8'hF0;
        wr(A_DATA, 8'h35);
        wr(A_DIR, 8'h0F);
        idle(6);
        check("R2 oe", pad_oe, 8'h0F);
        check("R2 driven bits", pad_out & pad_oe, 8'h05);
        rd(A_DATA, v); check("R2 mixed data read", v, 8'hF5);
        rd(8'h44, v);  check("R2 unmapped reads zero", v, 8'h00);

        // R8: output pins never flag
        wr(A_DIR, 8'hFF); wr(A_MODE, 8'h00); wr(A_SENS, 8'hFF);
        pad_in = 8'hFF; wr(A_ENA, 8'hFF); idle(8);
        rd(A_STAT, v); check("R8 outputs silent", v, 8'h00);
        check("R8 irq low", {7'd0, irq}, 8'h00);

        report();
    end

endmodule